// File: doc/BRIEF.md
# Shared-Port Burst Mover with Alternating Fill and Drain

This block copies one burst of bytes from a source address range to a destination address range. Each request carries both start addresses, a byte count and a flag that says whether the destination lives on the same bus port as the source. Reads always go out on port A. A same-port request also writes through port A, so reading and writing cannot overlap. The block then alternates. A fill phase reads bytes into a 16-entry staging buffer until the buffer is full or the request runs out. A drain phase then writes the buffer back out through port A until the buffer is empty. A request whose destination is on the other port writes through port B while reads continue on port A, and the buffer works as a plain stream.

The source engine holds one request at a time and takes a new one as soon as it has read the last byte of the current one. The destination engine may still be draining older bytes at that point. Each buffered byte carries its own destination address, its own same-port flag and its own end-of-request mark. Port A is handed to the destination by a go pulse from the source engine, and that pulse is built from the source engine's own latched flag. A fill that starts while an older request is still draining therefore still hands the port over, and the transfer cannot stall with a full buffer. A done pulse marks the end of each request.

Top module: `shared_port_mover`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, req_ready is 1 and a_valid, b_valid and done are 0.
- R2: A request is taken in a cycle where req_valid and req_ready are both 1. From the next cycle req_ready stays 0 until the source engine has read the last byte of that request, so at most one request waits behind the one being drained.
- R3: Byte i of a request (counting from 0) is read from req_src+i and written to req_dst+i with the value that was read. Reads and writes follow the order in which requests were taken.
- R4: The number of bytes read but not yet written never exceeds 16 (the buffer depth).
- R5: Once a same-port drain has written a byte on port A, no read is issued on port A until every buffered byte has been written.
- R6: A same-port request of 1 to 16 bytes gives all its reads on port A, then all its writes on port A (a single fill and a single drain).
- R7: A same-port request longer than 16 bytes gives runs of 16 reads and 16 writes in alternation. The last run pair is len mod 16 long, or 16 long when len is a multiple of 16.
- R8: A request with req_same=0 writes only on port B. Its reads stay on port A, and the two may overlap in time.
- R9: done is 1 for exactly one cycle per request: the cycle right after the write handshake of that request's last byte.
- R10: A new request is taken while an earlier one is still draining. A same-port request queued behind a drain of either kind completes without stalling.
- R11: A request with req_len=0 is taken, but it causes no bus traffic and no done pulse.
- R12: When a_valid or b_valid is 1 and the matching ready is 0, the valid stays 1 in the next cycle with the same address, the same a_we on port A and the same data on port B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Source engine idle; request taken when both high |
| req_src | input | 16 | First source byte address |
| req_dst | input | 16 | First destination byte address |
| req_len | input | 12 | Byte count |
| req_same | input | 1 | 1: destination on port A (shared); 0: destination on port B |
| a_valid | output | 1 | Port A access request |
| a_we | output | 1 | Port A direction: 1 write, 0 read |
| a_addr | output | 16 | Port A byte address |
| a_wdata | output | 8 | Port A write data |
| a_rdata | input | 8 | Port A read data, valid in the read handshake cycle |
| a_ready | input | 1 | Port A accepts the access this cycle |
| b_valid | output | 1 | Port B write request |
| b_addr | output | 16 | Port B byte address |
| b_wdata | output | 8 | Port B write data |
| b_ready | input | 1 | Port B accepts the write this cycle |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
Two events can land in the same cycle. One is a port A read that fills the buffer and raises the handover. The other is a port B write that frees an entry of an older other-port request. The full test must count both, or the handover comes too early or never. The bench provokes this by running a long other-port copy behind a slow port B and queuing a same-port copy right after it. Request acceptance then overlaps the older drain, and the bench judges the result by exact byte-by-byte address, data and port matching and by done arriving for both requests. Random mixes of request kinds and ready rates repeat this collision with many different timings.

// File: rtl/mover_pkg.sv
package mover_pkg;

    parameter int ADDR_W    = 16;
    parameter int DATA_W    = 8;
    parameter int LEN_W     = 12;
    parameter int BUF_DEPTH = 16;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [LEN_W-1:0]  len_t;

    // one staged byte with the context of the request it belongs to
    typedef struct packed {
        data_t data;
        addr_t waddr;
        logic  same;
        logic  last;
    } entry_t;

    // which engine currently drives port A
    typedef enum logic {
        OWN_SRC = 1'b0,
        OWN_DST = 1'b1
    } owner_e;

endpackage

// File: rtl/mover_stage_buf.sv
module mover_stage_buf
    import mover_pkg::*;
#(
    parameter int DEPTH = BUF_DEPTH,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  entry_t           push_entry,
    input  logic             pop,
    output entry_t           head,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    entry_t     slot_q [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) st_d.wr = bump(st_q.wr);
        if (pop)  st_d.rd = bump(st_q.rd);
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        head  = slot_q[st_q.rd];
        count = st_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) slot_q[st_q.wr] <= push_entry;
    end

endmodule

// File: rtl/mover_src_eng.sv
module mover_src_eng
    import mover_pkg::*;
#(
    parameter int DEPTH = BUF_DEPTH,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  addr_t            req_src,
    input  addr_t            req_dst,
    input  len_t             req_len,
    input  logic             req_same,
    output logic             req_ready,
    input  owner_e           owner,
    input  logic [CNT_W-1:0] buf_count,
    input  logic             buf_pop,
    output logic             rd_valid,
    output addr_t            rd_addr,
    input  logic             rd_ready,
    input  data_t            rd_data,
    output logic             push,
    output entry_t           push_entry,
    output logic             go
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W:0]   FULL_EXT = (CNT_W + 1)'(DEPTH);
    localparam len_t             LEN_ONE  = LEN_W'(1);

    typedef struct packed {
        logic  busy;
        addr_t raddr;
        addr_t waddr;
        len_t  remain;
        logic  same;
    } src_state_t;

    src_state_t s_d, s_q;
    logic       xfer;
    logic [CNT_W:0] fill_after;

    always_comb begin
        s_d        = s_q;
        req_ready  = !s_q.busy;
        rd_valid   = s_q.busy && (owner == OWN_SRC) && (buf_count < FULL_CNT);
        rd_addr    = s_q.raddr;
        xfer       = rd_valid && rd_ready;
        push       = xfer;
        push_entry = '{data: rd_data, waddr: s_q.waddr, same: s_q.same,
                       last: (s_q.remain == LEN_ONE)};
        // occupancy after this edge, counting a concurrent drain of an older entry
        fill_after = {1'b0, buf_count} + (CNT_W + 1)'(1) - (CNT_W + 1)'(buf_pop);
        // handover comes from this request's own latched flag
        go         = xfer && s_q.same && (push_entry.last || (fill_after == FULL_EXT));

        if (!s_q.busy) begin
            if (req_valid && (req_len != '0)) begin
                s_d.busy   = 1'b1;
                s_d.raddr  = req_src;
                s_d.waddr  = req_dst;
                s_d.remain = req_len;
                s_d.same   = req_same;
            end
        end else if (xfer) begin
            s_d.raddr  = s_q.raddr + 1'b1;
            s_d.waddr  = s_q.waddr + 1'b1;
            s_d.remain = s_q.remain - 1'b1;
            s_d.busy   = !push_entry.last;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/mover_dst_eng.sv
module mover_dst_eng
    import mover_pkg::*;
#(
    parameter int DEPTH = BUF_DEPTH,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] buf_count,
    input  entry_t           head,
    output logic             pop,
    input  logic             go,
    output owner_e           owner,
    output logic             a_wr_valid,
    output addr_t            a_wr_addr,
    output data_t            a_wr_data,
    input  logic             a_wr_ready,
    output logic             b_valid,
    output addr_t            b_addr,
    output data_t            b_wdata,
    input  logic             b_ready,
    output logic             done
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        owner_e owner;
        logic   done;
    } dst_state_t;

    dst_state_t d_d, d_q;
    logic       has;

    always_comb begin
        d_d        = d_q;
        has        = (buf_count != '0);
        a_wr_valid = has && head.same && (d_q.owner == OWN_DST);
        b_valid    = has && !head.same;
        a_wr_addr  = head.waddr;
        a_wr_data  = head.data;
        b_addr     = head.waddr;
        b_wdata    = head.data;
        pop        = (a_wr_valid && a_wr_ready) || (b_valid && b_ready);

        d_d.done = pop && head.last;
        if (go) begin
            d_d.owner = OWN_DST;
        end else if ((d_q.owner == OWN_DST) && pop && (buf_count == CNT_ONE)) begin
            d_d.owner = OWN_SRC;
        end

        owner = d_q.owner;
        done  = d_q.done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) d_q <= '{owner: OWN_SRC, done: 1'b0};
        else        d_q <= d_d;
    end

endmodule

// File: rtl/shared_port_mover.sv
module shared_port_mover
    import mover_pkg::*;
#(
    parameter int DEPTH = BUF_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_src,
    input  logic [ADDR_W-1:0] req_dst,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_same,
    output logic              a_valid,
    output logic              a_we,
    output logic [ADDR_W-1:0] a_addr,
    output logic [DATA_W-1:0] a_wdata,
    input  logic [DATA_W-1:0] a_rdata,
    input  logic              a_ready,
    output logic              b_valid,
    output logic [ADDR_W-1:0] b_addr,
    output logic [DATA_W-1:0] b_wdata,
    input  logic              b_ready,
    output logic              done
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] buf_count;
    entry_t           head, push_entry;
    logic             push, pop, go;
    owner_e           owner;
    logic             src_rd_valid, src_rd_ready;
    addr_t            src_rd_addr;
    logic             dst_a_valid, dst_a_ready;
    addr_t            dst_a_addr;
    data_t            dst_a_data;

    mover_stage_buf #(.DEPTH(DEPTH)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_entry (push_entry),
        .pop        (pop),
        .head       (head),
        .count      (buf_count)
    );

    mover_src_eng #(.DEPTH(DEPTH)) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_src    (req_src),
        .req_dst    (req_dst),
        .req_len    (req_len),
        .req_same   (req_same),
        .req_ready  (req_ready),
        .owner      (owner),
        .buf_count  (buf_count),
        .buf_pop    (pop),
        .rd_valid   (src_rd_valid),
        .rd_addr    (src_rd_addr),
        .rd_ready   (src_rd_ready),
        .rd_data    (a_rdata),
        .push       (push),
        .push_entry (push_entry),
        .go         (go)
    );

    mover_dst_eng #(.DEPTH(DEPTH)) u_dst (
        .clk        (clk),
        .rst_n      (rst_n),
        .buf_count  (buf_count),
        .head       (head),
        .pop        (pop),
        .go         (go),
        .owner      (owner),
        .a_wr_valid (dst_a_valid),
        .a_wr_addr  (dst_a_addr),
        .a_wr_data  (dst_a_data),
        .a_wr_ready (dst_a_ready),
        .b_valid    (b_valid),
        .b_addr     (b_addr),
        .b_wdata    (b_wdata),
        .b_ready    (b_ready),
        .done       (done)
    );

    // port A belongs to one engine at a time
    assign a_valid      = (owner == OWN_SRC) ? src_rd_valid : dst_a_valid;
    assign a_we         = (owner == OWN_DST);
    assign a_addr       = (owner == OWN_SRC) ? src_rd_addr : dst_a_addr;
    assign a_wdata      = dst_a_data;
    assign src_rd_ready = (owner == OWN_SRC) && a_ready;
    assign dst_a_ready  = (owner == OWN_DST) && a_ready;

endmodule

// File: rtl/mover_checker.sv
module mover_checker
    import mover_pkg::*;
#(
    parameter int DEPTH = BUF_DEPTH,
    localparam int OW = $clog2(DEPTH + 1) + 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              a_valid,
    input logic              a_we,
    input logic [ADDR_W-1:0] a_addr,
    input logic              a_ready,
    input logic              b_valid,
    input logic [ADDR_W-1:0] b_addr,
    input logic [DATA_W-1:0] b_wdata,
    input logic              b_ready,
    input logic              done
);

    logic          rd_hs, a_wr_hs, wr_hs;
    logic [OW-1:0] held_q, held_nx;
    logic          drain_q, drain_nx;

    always_comb begin
        rd_hs    = a_valid && !a_we && a_ready;
        a_wr_hs  = a_valid && a_we && a_ready;
        wr_hs    = a_wr_hs || (b_valid && b_ready);
        held_nx  = held_q + OW'(rd_hs) - OW'(wr_hs);
        drain_nx = a_wr_hs ? (held_nx != '0) : (drain_q && (held_nx != '0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q  <= '0;
            drain_q <= 1'b0;
        end else begin
            held_q  <= held_nx;
            drain_q <= drain_nx;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (req_ready && !a_valid && !b_valid && !done)); // R1

    AST_BUF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        held_q <= OW'(DEPTH)); // R4

    AST_NO_READ_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        drain_q |-> !(a_valid && !a_we)); // R5

    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_hs)); // R9

    AST_HOLD_PORT_A: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && !a_ready) |=> (a_valid && $stable(a_addr) && $stable(a_we))); // R12

    AST_HOLD_PORT_B: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && !b_ready) |=> (b_valid && $stable(b_addr) && $stable(b_wdata))); // R12

endmodule

bind shared_port_mover mover_checker #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .a_valid   (a_valid),
    .a_we      (a_we),
    .a_addr    (a_addr),
    .a_ready   (a_ready),
    .b_valid   (b_valid),
    .b_addr    (b_addr),
    .b_wdata   (b_wdata),
    .b_ready   (b_ready),
    .done      (done)
);

// File: tb/tb_shared_port_mover.sv
module tb_shared_port_mover;
    import mover_pkg::*;

    localparam int DEPTH = BUF_DEPTH;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic  rst_n, req_valid, req_ready, req_same;
    addr_t req_src, req_dst, a_addr, b_addr;
    len_t  req_len;
    logic  a_valid, a_we, a_ready, b_valid, b_ready, done;
    data_t a_wdata, a_rdata, b_wdata;

    shared_port_mover dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_src(req_src), .req_dst(req_dst), .req_len(req_len), .req_same(req_same),
        .a_valid(a_valid), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_ready(a_ready), .b_valid(b_valid), .b_addr(b_addr),
        .b_wdata(b_wdata), .b_ready(b_ready), .done(done)
    );

    function automatic data_t src_byte(input addr_t a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction
    assign a_rdata = src_byte(a_addr);

    int n_cmp = 0, n_bad = 0;
    int pct_a = 100, pct_b = 100;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        a_ready = int'($urandom_range(99, 0)) < pct_a;
        b_ready = int'($urandom_range(99, 0)) < pct_b;
    end

    // expected traffic
    addr_t exp_rd[$];
    addr_t exp_wa[$];
    data_t exp_wd[$];
    bit    exp_pa[$];
    bit    exp_last[$];

    int rd_cnt = 0, wr_cnt = 0, done_cnt = 0, outst = 0, outst_max = 0;
    int oplog[$];   // 0 read A, 1 write A, 2 write B
    bit log_en = 0, done_pend = 0;
    bit hold_a = 0, hold_b = 0, ha_we;
    addr_t ha_addr, hb_addr;
    data_t hb_data;

    always @(negedge clk) begin
        addr_t e_rd, wa;
        data_t wd;
        bit on_a, pa, lst;
        #3;
        if (rst_n) begin
            if (hold_a) chk(a_valid && a_addr == ha_addr && a_we == ha_we, "R12",
                            "port A request held", int'(a_addr), int'(ha_addr));
            if (hold_b) chk(b_valid && b_addr == hb_addr && b_wdata == hb_data, "R12",
                            "port B request held", int'(b_addr), int'(hb_addr));
            hold_a = a_valid && !a_ready; ha_addr = a_addr; ha_we = a_we;
            hold_b = b_valid && !b_ready; hb_addr = b_addr; hb_data = b_wdata;

            if (done || done_pend) chk(done == done_pend, "R9", "done pulse timing",
                                       int'(done), int'(done_pend));
            if (done) done_cnt++;
            done_pend = 0;

            if (a_valid && a_ready && !a_we) begin
                rd_cnt++; outst++;
                if (log_en) oplog.push_back(0);
                if (exp_rd.size() == 0) chk(0, "R3", "unexpected read", int'(a_addr), -1);
                else begin
                    e_rd = exp_rd.pop_front();
                    chk(a_addr == e_rd, "R3", "read address", int'(a_addr), int'(e_rd));
                end
            end
            on_a = a_valid && a_ready && a_we;
            if (on_a || (b_valid && b_ready)) begin
                wr_cnt++; outst--;
                if (log_en) oplog.push_back(on_a ? 1 : 2);
                if (exp_wa.size() == 0) chk(0, "R3", "unexpected write", 0, -1);
                else begin
                    wa = exp_wa.pop_front(); wd = exp_wd.pop_front();
                    pa = exp_pa.pop_front(); lst = exp_last.pop_front();
                    chk(on_a == pa, "R8", "write port (1=A)", int'(on_a), int'(pa));
                    chk((on_a ? a_addr : b_addr) == wa, "R3", "write address",
                        int'(on_a ? a_addr : b_addr), int'(wa));
                    chk((on_a ? a_wdata : b_wdata) == wd, "R3", "write data",
                        int'(on_a ? a_wdata : b_wdata), int'(wd));
                    done_pend = lst;
                end
            end
            if (outst > outst_max) outst_max = outst;
        end
    end

    int total = 0;
    int acc_outst = 0;

    task automatic send(input addr_t s, input addr_t d, input len_t n, input bit same);
        @(negedge clk);
        req_valid = 1; req_src = s; req_dst = d; req_len = n; req_same = same;
        #3;
        while (!req_ready) begin @(negedge clk); #3; end
        acc_outst = outst;
        for (int i = 0; i < int'(n); i++) begin
            exp_rd.push_back(s + addr_t'(i));
            exp_wa.push_back(d + addr_t'(i));
            exp_wd.push_back(src_byte(s + addr_t'(i)));
            exp_pa.push_back(same);
            exp_last.push_back(i == int'(n) - 1);
        end
        if (n != 0) total++;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic wait_dones(input int target);
        int t = 0;
        while (done_cnt < target && t < 20000) begin @(posedge clk); t++; end
        chk(done_cnt == target, "R10", "requests completed", done_cnt, target);
    endtask

    // isolated same-port burst: check the fill/drain run pattern
    task automatic run_same(input int len, input string tag);
        int rem = len, pos = 0, bad_at = -1, c;
        oplog.delete(); log_en = 1;
        send(16'h1000 + addr_t'(len), 16'h8000 + addr_t'(len), len_t'(len), 1'b1);
        wait_dones(total);
        log_en = 0;
        while (rem > 0) begin
            c = (rem > DEPTH) ? DEPTH : rem;
            for (int i = 0; i < 2 * c; i++) begin
                if (bad_at < 0 && (pos >= oplog.size() || oplog[pos] != ((i < c) ? 0 : 1)))
                    bad_at = pos;
                pos++;
            end
            rem -= c;
        end
        // R5: no read may appear inside a drain run
        chk(bad_at < 0 && oplog.size() == 2 * len, tag, "fill/drain pattern (first bad op)",
            bad_at, -1);
    endtask

    initial begin
        int r0, w0, d0, nb, na;
        void'($urandom(32'd777));
        rst_n = 0; req_valid = 0; req_src = '0; req_dst = '0; req_len = '0; req_same = 0;
        repeat (5) @(negedge clk);
        #3;
        chk(req_ready && !a_valid && !b_valid && !done, "R1", "idle in reset",
            int'({req_ready, a_valid, b_valid, done}), 8);
        @(negedge clk); rst_n = 1;
        #3;
        chk(req_ready && !a_valid && !b_valid && !done, "R1", "idle after reset",
            int'({req_ready, a_valid, b_valid, done}), 8);

        // R2: busy while reading
        send(16'h0200, 16'h0300, 12'd10, 1'b1);
        #3;
        chk(!req_ready, "R2", "req_ready after accept", int'(req_ready), 0);
        wait_dones(total);
        #1;
        chk(req_ready, "R2", "req_ready after completion", int'(req_ready), 1);

        // R6 / R7 single-request patterns
        pct_a = 70;
        run_same(1, "R6");
        run_same(5, "R6");
        run_same(16, "R6");
        outst_max = 0;
        run_same(37, "R7");
        chk(outst_max == DEPTH, "R4", "peak occupancy on long burst", outst_max, DEPTH);
        run_same(32, "R7");
        run_same(17, "R7");

        // R8: other-port request
        pct_a = 100; pct_b = 60;
        oplog.delete(); log_en = 1;
        send(16'h4400, 16'h5500, 12'd20, 1'b0);
        wait_dones(total);
        log_en = 0;
        nb = 0; na = 0;
        foreach (oplog[i]) begin if (oplog[i] == 2) nb++; if (oplog[i] == 1) na++; end
        chk(nb == 20 && na == 0, "R8", "port B writes (A writes must be 0)", nb * 100 + na, 2000);

        // R11: zero length
        r0 = rd_cnt; w0 = wr_cnt; d0 = done_cnt;
        send(16'h0100, 16'h0180, 12'd0, 1'b1);
        repeat (20) @(negedge clk);
        #3;
        chk(rd_cnt == r0 && wr_cnt == w0 && done_cnt == d0, "R11", "traffic from empty request",
            (rd_cnt - r0) + (wr_cnt - w0) + (done_cnt - d0), 0);
        chk(req_ready, "R11", "ready after empty request", int'(req_ready), 1);

        // R10: same-port fill behind a slow other-port drain
        pct_a = 100; pct_b = 25;
        send(16'h1100, 16'h2200, 12'd40, 1'b0);
        send(16'h3300, 16'h4400, 12'd30, 1'b1);
        chk(acc_outst > 0, "R10", "accepted while earlier request draining", acc_outst, 1);
        wait_dones(total);

        // random mix
        for (int k = 0; k < 40; k++) begin
            pct_a = 40 + int'($urandom_range(60, 0));
            pct_b = 40 + int'($urandom_range(60, 0));
            send(addr_t'($urandom), addr_t'($urandom), len_t'($urandom_range(48, 1)),
                 1'($urandom));
        end
        wait_dones(total);
        repeat (5) @(negedge clk);
        #3;
        chk(exp_wa.size() == 0 && exp_rd.size() == 0, "R3", "leftover expected bytes",
            exp_wa.size() + exp_rd.size(), 0);
        chk(outst_max <= DEPTH, "R4", "peak bytes held", outst_max, DEPTH);
        chk(req_ready && !a_valid && !b_valid, "R2", "idle at end",
            int'({req_ready, a_valid, b_valid}), 4);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL R10 watchdog expired actual=%0d expected=%0d", done_cnt, total);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule